// File: doc/BRIEF.md
# Capture and Up/Down Reload Timer

A 16-bit timer/counter with a companion 16-bit register that can act as a capture register or as a reload value. The count advances once per machine cycle. The design has no divider of its own: the surrounding logic supplies a one-cycle strobe for each machine cycle. Instead of the strobe, the count can also follow falling edges on an external count pin. A second external pin, the trigger, has two roles. It can be a capture or reload strobe. In the up/down mode it is read as a live level that sets the count direction.

Three modes are available:
- **Capture:** a trigger falling edge copies the running count into the companion register.
- **Up-only reload:** rollover, or a trigger falling edge, loads the count from the companion register.
- **Up/down reload:** the trigger level picks the direction. Underflow is found by comparing the count with the companion register. The external flag then toggles and serves as a 17th count bit.

Software writes the count and companion register through write ports. It clears the two sticky flags with clear strobes. The block raises one interrupt request.

Top module: `cap_reload_timer`

## Requirements
- R1: Synchronous reset clears the count, the companion register, both flags, the interrupt request and both edge-detector samples to 0.
- R2: With run=1 and count-select=0, the count increments by one on every cycle where the machine-cycle strobe `tick` is 1, and on no other cycle.
- R3: With run=0, the count holds its value. The exceptions are a software count write and a trigger-forced reload.
- R4: With count-select=1, each pin is sampled on strobe cycles only. A count event (when running) occurs on a strobe cycle where the previous strobe sample of `cnt_pin` was 1 and the pin is now 0.
- R5: In capture mode (`cap_sel`=1), a count step from 0xFFFF gives 0x0000 and sets the overflow flag.
- R6: In capture mode with `trig_en`=1, a trigger falling edge (detected as in R4) copies the count value from before that cycle's step into the companion register and sets the external flag. With `trig_en`=0, trigger edges change neither.
- R7: In up-only reload mode (`cap_sel`=0, `dn_en`=0), a count step from 0xFFFF loads the companion register value into the count and sets the overflow flag.
- R8: In up-only reload mode with `trig_en`=1, a trigger falling edge loads the count from the companion register and sets the external flag. This load replaces any count step in the same cycle.
- R9: In up/down mode (`cap_sel`=0, `dn_en`=1), a step counts up when `trig_pin`=1 and down when it is 0. A down step taken while the count equals the companion register loads 0xFFFF and sets the overflow flag. An up step from 0xFFFF reloads as in R7.
- R10: In up/down mode, every rollover or underflow inverts the external flag, and trigger edges neither load nor set anything.
- R11: `irq` is the overflow flag ORed with the external flag, except that the external flag is excluded in up/down mode. Flags stay set until their clear strobe. A flag event in the same cycle as a clear wins.
- R12: A count write replaces the count produced by hardware in that cycle, though the cycle's flag events still take effect. A companion write likewise overrides a capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Machine-cycle strobe, one clock wide |
| cnt_pin | input | 1 | External count input |
| trig_pin | input | 1 | Trigger strobe / direction level |
| run | input | 1 | Enables counting |
| ext_clk_sel | input | 1 | 1: count pin falling edges; 0: machine cycles |
| trig_en | input | 1 | Enables trigger capture/reload action |
| cap_sel | input | 1 | 1: capture mode; 0: reload modes |
| dn_en | input | 1 | Enables up/down counting in reload mode |
| wr_cnt_en | input | 1 | Count write strobe |
| wr_cnt_data | input | 16 | Count write value |
| wr_rld_en | input | 1 | Companion register write strobe |
| wr_rld_data | input | 16 | Companion register write value |
| ovf_clr | input | 1 | Clears overflow flag |
| ext_clr | input | 1 | Clears external flag |
| count | output | 16 | Current count |
| rld_val | output | 16 | Companion (capture/reload) register |
| ovf_flag | output | 1 | Overflow/underflow flag |
| ext_flag | output | 1 | External flag |
| irq | output | 1 | Interrupt request |

## Verification
Two situations are the hardest to reach from the ports.

The first is an underflow in up/down mode. It happens only when the count, walking down, meets the companion value on a strobe cycle. The stimulus writes the count a few steps above a chosen companion value, holds the trigger low, and lets it walk through. It then raises the trigger to climb through 0xFFFF, so that the external flag inverts twice.

The second is the set of same-cycle collisions between a count or companion write and a rollover or capture. To produce them, the bench watches the strobe it generates itself and places the write strobe on the very clock whose edge carries the step.

// File: rtl/crt_pkg.sv
package crt_pkg;

    typedef enum logic [1:0] {
        CRT_CAPTURE     = 2'd0,
        CRT_RELOAD_UP   = 2'd1,
        CRT_RELOAD_UPDN = 2'd2
    } crt_mode_e;

    typedef struct packed {
        logic run;
        logic ext_clk_sel;
        logic trig_en;
        logic cap_sel;
        logic dn_en;
    } crt_ctrl_t;

    typedef struct packed {
        logic wrap;        // rollover or underflow
        logic trig_hit;    // trigger action sets external flag
        logic ext_toggle;  // up/down mode: invert external flag
    } crt_evt_t;

    function automatic crt_mode_e crt_mode_of(crt_ctrl_t c);
        if (c.cap_sel)
            return CRT_CAPTURE;
        else if (c.dn_en)
            return CRT_RELOAD_UPDN;
        else
            return CRT_RELOAD_UP;
    endfunction

endpackage

// File: rtl/crt_fall_det.sv
module crt_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pin,
    output logic fall
);
    logic last_q;

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= 1'b0;
        else if (tick)
            last_q <= pin;
    end

    assign fall = tick && last_q && !pin;

    AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
        fall |=> !last_q); // R4

endmodule

// File: rtl/crt_count_core.sv
module crt_count_core
    import crt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  crt_ctrl_t    ctrl,
    input  crt_mode_e    mode,
    input  logic         tick,
    input  logic         cnt_fall,
    input  logic         trig_fall,
    input  logic         trig_lvl,
    input  logic         wr_cnt_en,
    input  logic [W-1:0] wr_cnt_data,
    input  logic         wr_rld_en,
    input  logic [W-1:0] wr_rld_data,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] rld_q,
    output crt_evt_t     evt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic         step;
    logic         go_up;
    logic         trig_act;
    logic         at_top;
    logic         at_floor;
    logic [W-1:0] cnt_d;
    logic [W-1:0] rld_d;

    assign step     = ctrl.run && (ctrl.ext_clk_sel ? cnt_fall : tick);
    assign go_up    = (mode != CRT_RELOAD_UPDN) || trig_lvl;
    assign trig_act = ctrl.trig_en && trig_fall && (mode != CRT_RELOAD_UPDN);
    assign at_top   = (cnt_q == TOP);
    assign at_floor = (cnt_q == rld_q);

    always_comb begin
        cnt_d = cnt_q;
        rld_d = rld_q;
        evt   = '0;
        unique case (mode)
            CRT_CAPTURE: begin
                if (step) begin
                    cnt_d    = cnt_q + ONE;
                    evt.wrap = at_top;
                end
                if (trig_act) begin
                    rld_d        = cnt_q;
                    evt.trig_hit = 1'b1;
                end
            end
            CRT_RELOAD_UP: begin
                if (trig_act) begin
                    cnt_d        = rld_q;
                    evt.trig_hit = 1'b1;
                end else if (step) begin
                    if (at_top) begin
                        cnt_d    = rld_q;
                        evt.wrap = 1'b1;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
            end
            CRT_RELOAD_UPDN: begin
                if (step) begin
                    if (go_up) begin
                        if (at_top) begin
                            cnt_d          = rld_q;
                            evt.wrap       = 1'b1;
                            evt.ext_toggle = 1'b1;
                        end else begin
                            cnt_d = cnt_q + ONE;
                        end
                    end else begin
                        if (at_floor) begin
                            cnt_d          = TOP;
                            evt.wrap       = 1'b1;
                            evt.ext_toggle = 1'b1;
                        end else begin
                            cnt_d = cnt_q - ONE;
                        end
                    end
                end
            end
            default: ;
        endcase
        if (wr_cnt_en)
            cnt_d = wr_cnt_data;
        if (wr_rld_en)
            rld_d = wr_rld_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            rld_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            rld_q <= rld_d;
        end
    end

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !wr_cnt_en &&
         !(mode == CRT_RELOAD_UP && ctrl.trig_en && trig_fall))
        |=> $stable(cnt_q)); // R3

    AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (mode == CRT_RELOAD_UP && step && cnt_q == TOP && !trig_fall && !wr_cnt_en)
        |=> cnt_q == $past(rld_q)); // R7

    AST_UNDERFLOW_TOP: assert property (@(posedge clk) disable iff (rst)
        (mode == CRT_RELOAD_UPDN && step && !trig_lvl && cnt_q == rld_q && !wr_cnt_en)
        |=> cnt_q == TOP); // R9

endmodule

// File: rtl/crt_flag_unit.sv
module crt_flag_unit
    import crt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  crt_mode_e mode,
    input  crt_evt_t  evt,
    input  logic      ovf_clr,
    input  logic      ext_clr,
    output logic      ovf_q,
    output logic      ext_q,
    output logic      irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
            ext_q <= 1'b0;
        end else begin
            if (evt.wrap)
                ovf_q <= 1'b1;
            else if (ovf_clr)
                ovf_q <= 1'b0;

            if (evt.ext_toggle)
                ext_q <= !ext_q;
            else if (evt.trig_hit)
                ext_q <= 1'b1;
            else if (ext_clr)
                ext_q <= 1'b0;
        end
    end

    assign irq = ovf_q || (ext_q && (mode != CRT_RELOAD_UPDN));

    AST_EXT_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        evt.ext_toggle |=> ext_q != $past(ext_q)); // R10

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !ovf_clr) |=> ovf_q); // R11

endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
    import crt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         cnt_pin,
    input  logic         trig_pin,
    input  logic         run,
    input  logic         ext_clk_sel,
    input  logic         trig_en,
    input  logic         cap_sel,
    input  logic         dn_en,
    input  logic         wr_cnt_en,
    input  logic [W-1:0] wr_cnt_data,
    input  logic         wr_rld_en,
    input  logic [W-1:0] wr_rld_data,
    input  logic         ovf_clr,
    input  logic         ext_clr,
    output logic [W-1:0] count,
    output logic [W-1:0] rld_val,
    output logic         ovf_flag,
    output logic         ext_flag,
    output logic         irq
);
    crt_ctrl_t ctrl;
    crt_mode_e mode;
    crt_evt_t  evt;
    logic      cnt_fall;
    logic      trig_fall;

    assign ctrl = '{run: run, ext_clk_sel: ext_clk_sel, trig_en: trig_en,
                    cap_sel: cap_sel, dn_en: dn_en};
    assign mode = crt_mode_of(ctrl);

    crt_fall_det u_cnt_det (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .pin  (cnt_pin),
        .fall (cnt_fall)
    );

    crt_fall_det u_trig_det (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .pin  (trig_pin),
        .fall (trig_fall)
    );

    crt_count_core #(.W(W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .ctrl        (ctrl),
        .mode        (mode),
        .tick        (tick),
        .cnt_fall    (cnt_fall),
        .trig_fall   (trig_fall),
        .trig_lvl    (trig_pin),
        .wr_cnt_en   (wr_cnt_en),
        .wr_cnt_data (wr_cnt_data),
        .wr_rld_en   (wr_rld_en),
        .wr_rld_data (wr_rld_data),
        .cnt_q       (count),
        .rld_q       (rld_val),
        .evt         (evt)
    );

    crt_flag_unit u_flags (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .evt     (evt),
        .ovf_clr (ovf_clr),
        .ext_clr (ext_clr),
        .ovf_q   (ovf_flag),
        .ext_q   (ext_flag),
        .irq     (irq)
    );

    AST_IRQ_ON_OVF: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |-> irq); // R11

endmodule

// File: tb/tb_cap_reload_timer.sv
module tb_cap_reload_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        cnt_pin = 1'b0, trig_pin = 1'b0;
    logic        run = 1'b0, ext_clk_sel = 1'b0, trig_en = 1'b0;
    logic        cap_sel = 1'b1, dn_en = 1'b0;
    logic        wr_cnt_en = 1'b0, wr_rld_en = 1'b0;
    logic [15:0] wr_cnt_data = '0, wr_rld_data = '0;
    logic        ovf_clr = 1'b0, ext_clr = 1'b0;
    logic [15:0] count, rld_val;
    logic        ovf_flag, ext_flag, irq;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    armed = 0;
    string phase = "R1";
    int    tick_per = 3;
    int    tick_cnt = 0;

    // reference model state
    int m_cnt, m_rld, m_mode, nc, nr;
    bit m_ovf, m_ext, m_lc, m_lt, cf, tf, stp, wrp, hit, tgl;

    cap_reload_timer dut (
        .clk(clk), .rst(rst), .tick(tick), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
        .run(run), .ext_clk_sel(ext_clk_sel), .trig_en(trig_en), .cap_sel(cap_sel),
        .dn_en(dn_en), .wr_cnt_en(wr_cnt_en), .wr_cnt_data(wr_cnt_data),
        .wr_rld_en(wr_rld_en), .wr_rld_data(wr_rld_data), .ovf_clr(ovf_clr),
        .ext_clr(ext_clr), .count(count), .rld_val(rld_val), .ovf_flag(ovf_flag),
        .ext_flag(ext_flag), .irq(irq)
    );

    always #5 clk = !clk;

    always begin
        @(posedge clk);
        #1;
        if (tick_cnt >= tick_per - 1) begin
            tick_cnt = 0;
            tick = 1'b1;
        end else begin
            tick_cnt = tick_cnt + 1;
            tick = 1'b0;
        end
    end

    function automatic int cur_mode();
        if (cap_sel) return 0;
        if (dn_en) return 2;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_rld = 0; m_ovf = 0; m_ext = 0; m_lc = 0; m_lt = 0;
        end else begin
            m_mode = cur_mode();
            cf = tick && m_lc && !cnt_pin;
            tf = tick && m_lt && !trig_pin;
            if (tick) begin
                m_lc = cnt_pin;
                m_lt = trig_pin;
            end
            stp = run && (ext_clk_sel ? cf : tick);
            wrp = 0; hit = 0; tgl = 0;
            nc = m_cnt; nr = m_rld;
            if (m_mode == 0) begin
                if (stp) begin
                    wrp = (m_cnt == 65535);
                    nc = (m_cnt + 1) % 65536;
                end
                if (trig_en && tf) begin
                    nr = m_cnt; hit = 1;
                end
            end else if (m_mode == 1) begin
                if (trig_en && tf) begin
                    nc = m_rld; hit = 1;
                end else if (stp) begin
                    if (m_cnt == 65535) begin nc = m_rld; wrp = 1; end
                    else nc = m_cnt + 1;
                end
            end else if (stp) begin
                if (trig_pin) begin
                    if (m_cnt == 65535) begin nc = m_rld; wrp = 1; tgl = 1; end
                    else nc = m_cnt + 1;
                end else begin
                    if (m_cnt == m_rld) begin nc = 65535; wrp = 1; tgl = 1; end
                    else nc = m_cnt - 1;
                end
            end
            if (wr_cnt_en) nc = wr_cnt_data;
            if (wr_rld_en) nr = wr_rld_data;
            if (wrp) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
            if (tgl) m_ext = !m_ext; else if (hit) m_ext = 1; else if (ext_clr) m_ext = 0;
            m_cnt = nc; m_rld = nr;
            armed = 1;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed && !rst) begin
            check({phase, " count"}, count, m_cnt);
            check({phase, " rld"}, rld_val, m_rld);
            check({phase, " ovf"}, ovf_flag, m_ovf);
            check({phase, " ext"}, ext_flag, m_ext);
            check({phase, " irq"}, irq, int'(m_ovf | (m_ext & (cur_mode() != 2))));
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr_cnt(int v);
        wr_cnt_data = v[15:0]; wr_cnt_en = 1; step(1); wr_cnt_en = 0;
    endtask

    task automatic wr_rld(int v);
        wr_rld_data = v[15:0]; wr_rld_en = 1; step(1); wr_rld_en = 0;
    endtask

    task automatic wait_tick();
        while (tick !== 1'b1) step(1);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int hold;
        step(3);
        rst = 0;
        step(1);
        // R1 reset state
        phase = "R1";
        check("R1 count", count, 0);
        check("R1 rld", rld_val, 0);
        check("R1 flags", {ovf_flag, ext_flag}, 0);
        check("R1 irq", irq, 0);

        // R2 timer function, R5 rollover in capture mode
        phase = "R2";
        wr_cnt(16'hFFF8);
        run = 1;
        step(20);
        phase = "R5";
        step(20);
        check("R5 ovf set", ovf_flag, 1);
        check("R11 irq from ovf", irq, 1);

        // R3 stop holds
        phase = "R3";
        run = 0;
        step(1);
        hold = count;
        step(20);
        check("R3 held", count, hold);

        // R11 clear
        phase = "R11";
        ovf_clr = 1; step(1); ovf_clr = 0; step(1);
        check("R11 cleared", ovf_flag, 0);

        // R4 counter function
        phase = "R4";
        ext_clk_sel = 1; run = 1;
        for (int i = 0; i < 8; i++) begin
            cnt_pin = 1; step(12);
            cnt_pin = 0; step(12);
        end
        cnt_pin = 1; step(3); cnt_pin = 0; step(1); cnt_pin = 1; step(9);
        ext_clk_sel = 0;

        // R6 capture with trigger disabled, then enabled
        phase = "R6";
        trig_en = 0;
        trig_pin = 1; step(9); trig_pin = 0; step(9);
        check("R6 no ext when disabled", ext_flag, 0);
        trig_en = 1;
        for (int i = 0; i < 3; i++) begin
            trig_pin = 1; step(9); trig_pin = 0; step(9);
        end
        check("R6 ext set", ext_flag, 1);
        ext_clr = 1; step(1); ext_clr = 0; step(1);

        // R12 companion write beats capture
        phase = "R12";
        trig_pin = 1; step(9); wait_tick();
        trig_pin = 0; wr_rld_data = 16'hBEEF; wr_rld_en = 1; step(1); wr_rld_en = 0;
        check("R12 rld write wins", rld_val, 16'hBEEF);
        step(3);
        ext_clr = 1; step(1); ext_clr = 0;

        // R7 reload up
        phase = "R7";
        cap_sel = 0; trig_en = 0;
        wr_rld(16'hFFF0);
        wr_cnt(16'hFFFA);
        step(60);
        ovf_clr = 1; step(1); ovf_clr = 0;

        // R8 trigger forced reload
        phase = "R8";
        wr_cnt(16'h0100);
        trig_en = 1;
        trig_pin = 1; step(9); trig_pin = 0; step(12);
        check("R8 ext set", ext_flag, 1);

        // R12 count write in the cycle of a rollover
        phase = "R12";
        trig_en = 0;
        wr_cnt(16'hFFFF);
        wait_tick();
        wr_cnt_data = 16'h0100; wr_cnt_en = 1; step(1); wr_cnt_en = 0;
        step(2);
        ext_clr = 1; ovf_clr = 1; step(1); ext_clr = 0; ovf_clr = 0;

        // R9 / R10 up/down mode
        phase = "R9";
        run = 0; dn_en = 1; trig_en = 1;
        wr_rld(16'h0010);
        wr_cnt(16'h0014);
        trig_pin = 0;
        run = 1;
        step(30);
        check("R9 underflow flag", ovf_flag, 1);
        phase = "R10";
        trig_pin = 1;
        step(20);
        trig_pin = 0; step(6); trig_pin = 1; step(6);
        ext_clr = 1; step(1); ext_clr = 0;
        ovf_clr = 1; step(1); ovf_clr = 0;
        step(6);
        check("R10 irq excludes ext", irq, 0);

        // R11 set beats clear
        phase = "R11";
        dn_en = 0; trig_en = 0;
        wr_cnt(16'hFFFF);
        wait_tick();
        ovf_clr = 1; step(1); ovf_clr = 0;
        check("R11 set wins over clear", ovf_flag, 1);
        step(10);

        finish_run();
    end

endmodule